// File: doc/BRIEF.md
# Configurable Two-Input Gate Layer

This block implements one layer of a logic-gate network. It has a fixed number of neurons. Each neuron reads two bits, called a and b, from a wide layer input bus. Every neuron holds its own pair of operand indices and a 4-bit function code. The code selects any one of the sixteen Boolean functions of two variables. The result is a single output bit per neuron. The path from `layer_in` to `layer_out` is purely combinational, so a new input vector is answered within the same cycle.

The per-neuron settings sit in registers. They are loaded one neuron at a time through a synchronous write port: a strobe, a neuron number, two operand indices and a function code. After a synchronous reset every neuron passes operand a through, and both of its operand indices point at input bit 0.

Top module: `gate_layer`

## Requirements
- R1: After reset, and until the first accepted configuration write, every output bit equals `layer_in[0]`.
- R2: A write with `cfg_we` high changes the addressed neuron's behaviour from the next rising clock edge on. During the cycle in which the write is presented, the old setting is still visible.
- R3: Function codes 0, 1, 2 and 3 give constant 0, a AND b, a AND (NOT b), and a.
- R4: Function codes 4, 5, 6 and 7 give (NOT a) AND b, b, a XOR b, and a OR b.
- R5: Function codes 8, 9, 10 and 11 give NOT (a OR b), NOT (a XOR b), NOT b, and (NOT b) OR a.
- R6: Function codes 12, 13, 14 and 15 give NOT a, (NOT a) OR b, NOT (a AND b), and constant 1.
- R7: An operand index equal to or greater than `IN_W` supplies the value 0 for that operand.
- R8: A write whose neuron number is equal to or greater than `N_NEU` changes no neuron.
- R9: While `cfg_we` is low, changes on the other configuration inputs leave every neuron's setting unchanged.
- R10: `layer_out` follows a change of `layer_in` within the same clock cycle, with no register in between.
- R11: `layer_out` never carries X or Z while `layer_in` is fully known, whatever the function codes are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset of all neuron settings |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_neuron | input | NID_W | Number of the neuron being written |
| cfg_src_a | input | IDX_W | Input bit index for operand a |
| cfg_src_b | input | IDX_W | Input bit index for operand b |
| cfg_code | input | 4 | Function code, 0 to 15 |
| layer_in | input | IN_W | Layer input vector |
| layer_out | output | N_NEU | One result bit per neuron |

## Verification
The checker assumes that `layer_in` and the configuration inputs are known at every sampling edge. It also assumes that the width parameters are large enough to express an out-of-range neuron number and an out-of-range operand index, which the default derivation guarantees. The stability properties only judge cycles in which `layer_in` does not change. For that reason the bench drives inputs shortly after a rising edge and holds them for a whole cycle, and it never toggles the write strobe and the input vector in the middle of a cycle.

// File: rtl/gate_layer_pkg.sv
package gate_layer_pkg;

  typedef enum logic [3:0] {
    OP_ZERO      = 4'd0,
    OP_AND       = 4'd1,
    OP_A_ANDN_B  = 4'd2,
    OP_PASS_A    = 4'd3,
    OP_NA_AND_B  = 4'd4,
    OP_PASS_B    = 4'd5,
    OP_XOR       = 4'd6,
    OP_OR        = 4'd7,
    OP_NOR       = 4'd8,
    OP_XNOR      = 4'd9,
    OP_NOT_B     = 4'd10,
    OP_NB_OR_A   = 4'd11,
    OP_NOT_A     = 4'd12,
    OP_NA_OR_B   = 4'd13,
    OP_NAND      = 4'd14,
    OP_ONE       = 4'd15
  } gate_op_e;

  localparam gate_op_e OP_AFTER_RESET = OP_PASS_A;

endpackage

// File: rtl/gl_cfg_bank.sv
module gl_cfg_bank
  import gate_layer_pkg::*;
#(
  parameter int N_NEU = 8,
  parameter int IDX_W = 5,
  parameter int NID_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [NID_W-1:0]            wr_slot,
  input  logic [IDX_W-1:0]            wr_sel_a,
  input  logic [IDX_W-1:0]            wr_sel_b,
  input  logic [3:0]                  wr_op,
  output gate_op_e [N_NEU-1:0]        op_o,
  output logic [N_NEU-1:0][IDX_W-1:0] sel_a_o,
  output logic [N_NEU-1:0][IDX_W-1:0] sel_b_o
);

  for (genvar i = 0; i < N_NEU; i++) begin : g_slot
    logic             hit;
    gate_op_e         op_q;
    logic [IDX_W-1:0] sel_a_q;
    logic [IDX_W-1:0] sel_b_q;

    // A slot number beyond N_NEU never matches any i, so it is dropped.
    assign hit = wr_en && (wr_slot == NID_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        op_q    <= OP_AFTER_RESET;
        sel_a_q <= '0;
        sel_b_q <= '0;
      end else if (hit) begin
        op_q    <= gate_op_e'(wr_op);
        sel_a_q <= wr_sel_a;
        sel_b_q <= wr_sel_b;
      end
    end

    assign op_o[i]    = op_q;
    assign sel_a_o[i] = sel_a_q;
    assign sel_b_o[i] = sel_b_q;
  end

endmodule

// File: rtl/gl_operand_pick.sv
module gl_operand_pick #(
  parameter int IN_W  = 16,
  parameter int IDX_W = 5
) (
  input  logic [IN_W-1:0]  vec,
  input  logic [IDX_W-1:0] sel,
  output logic             bit_o
);

  // Compare-and-select form: an index past IN_W matches nothing and yields 0.
  always_comb begin
    bit_o = 1'b0;
    for (int k = 0; k < IN_W; k++) begin
      if (sel == IDX_W'(k)) bit_o = vec[k];
    end
  end

endmodule

// File: rtl/gl_gate_eval.sv
module gl_gate_eval
  import gate_layer_pkg::*;
(
  input  gate_op_e op,
  input  logic     a,
  input  logic     b,
  output logic     y
);

  always_comb begin
    y = 1'b0;
    unique case (op)
      OP_ZERO:     y = 1'b0;
      OP_AND:      y = a & b;
      OP_A_ANDN_B: y = a & ~b;
      OP_PASS_A:   y = a;
      OP_NA_AND_B: y = ~a & b;
      OP_PASS_B:   y = b;
      OP_XOR:      y = a ^ b;
      OP_OR:       y = a | b;
      OP_NOR:      y = ~(a | b);
      OP_XNOR:     y = ~(a ^ b);
      OP_NOT_B:    y = ~b;
      OP_NB_OR_A:  y = ~b | a;
      OP_NOT_A:    y = ~a;
      OP_NA_OR_B:  y = ~a | b;
      OP_NAND:     y = ~(a & b);
      OP_ONE:      y = 1'b1;
    endcase
  end

endmodule

// File: rtl/gate_layer.sv
module gate_layer
  import gate_layer_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int N_NEU = 8,
  parameter int IDX_W = $clog2(IN_W) + 1,
  parameter int NID_W = $clog2(N_NEU) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [NID_W-1:0]  cfg_neuron,
  input  logic [IDX_W-1:0]  cfg_src_a,
  input  logic [IDX_W-1:0]  cfg_src_b,
  input  logic [3:0]        cfg_code,
  input  logic [IN_W-1:0]   layer_in,
  output logic [N_NEU-1:0]  layer_out
);

  gate_op_e [N_NEU-1:0]        slot_op;
  logic [N_NEU-1:0][IDX_W-1:0] slot_sel_a;
  logic [N_NEU-1:0][IDX_W-1:0] slot_sel_b;

  gl_cfg_bank #(
    .N_NEU (N_NEU),
    .IDX_W (IDX_W),
    .NID_W (NID_W)
  ) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_slot  (cfg_neuron),
    .wr_sel_a (cfg_src_a),
    .wr_sel_b (cfg_src_b),
    .wr_op    (cfg_code),
    .op_o     (slot_op),
    .sel_a_o  (slot_sel_a),
    .sel_b_o  (slot_sel_b)
  );

  for (genvar n = 0; n < N_NEU; n++) begin : g_neuron
    logic opnd_a;
    logic opnd_b;

    gl_operand_pick #(
      .IN_W  (IN_W),
      .IDX_W (IDX_W)
    ) u_pick_a (
      .vec   (layer_in),
      .sel   (slot_sel_a[n]),
      .bit_o (opnd_a)
    );

    gl_operand_pick #(
      .IN_W  (IN_W),
      .IDX_W (IDX_W)
    ) u_pick_b (
      .vec   (layer_in),
      .sel   (slot_sel_b[n]),
      .bit_o (opnd_b)
    );

    gl_gate_eval u_eval (
      .op (slot_op[n]),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (layer_out[n])
    );
  end

endmodule

// File: rtl/gate_layer_chk.sv
module gate_layer_chk #(
  parameter int IN_W  = 16,
  parameter int N_NEU = 8,
  parameter int IDX_W = $clog2(IN_W) + 1,
  parameter int NID_W = $clog2(N_NEU) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [NID_W-1:0]  cfg_neuron,
  input logic [IDX_W-1:0]  cfg_src_a,
  input logic [IDX_W-1:0]  cfg_src_b,
  input logic [3:0]        cfg_code,
  input logic [IN_W-1:0]   layer_in,
  input logic [N_NEU-1:0]  layer_out
);

  function automatic logic out_at(logic [N_NEU-1:0] v, logic [NID_W-1:0] n);
    logic r;
    r = 1'b0;
    for (int k = 0; k < N_NEU; k++) if (n == NID_W'(k)) r = v[k];
    return r;
  endfunction

  function automatic logic in_at(logic [IN_W-1:0] v, logic [IDX_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int k = 0; k < IN_W; k++) if (s == IDX_W'(k)) r = v[k];
    return r;
  endfunction

  logic slot_ok;
  logic touched;

  assign slot_ok = cfg_neuron < NID_W'(N_NEU);

  always_ff @(posedge clk) begin
    if (rst)                    touched <= 1'b0;
    else if (cfg_we && slot_ok) touched <= 1'b1;
  end

  AST_RESET_PASSES_BIT0: assert property (@(posedge clk) disable iff (rst)
    !touched |-> layer_out == {N_NEU{layer_in[0]}});  // R1

  AST_WRITE_NEXT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && slot_ok && cfg_code == 4'd3 && cfg_src_a < IDX_W'(IN_W))
    |=> out_at(layer_out, $past(cfg_neuron)) == in_at(layer_in, $past(cfg_src_a)));  // R2

  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && slot_ok && cfg_code == 4'd0) |=> !out_at(layer_out, $past(cfg_neuron)));  // R3

  AST_CODE_ONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && slot_ok && cfg_code == 4'd15) |=> out_at(layer_out, $past(cfg_neuron)));  // R6

  AST_SRC_A_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && slot_ok && cfg_code == 4'd3 && cfg_src_a >= IDX_W'(IN_W))
    |=> !out_at(layer_out, $past(cfg_neuron)));  // R7

  AST_SRC_B_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && slot_ok && cfg_code == 4'd5 && cfg_src_b >= IDX_W'(IN_W))
    |=> !out_at(layer_out, $past(cfg_neuron)));  // R7

  AST_BAD_SLOT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !slot_ok) ##1 $stable(layer_in) |-> $stable(layer_out));  // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cfg_we ##1 $stable(layer_in) |-> $stable(layer_out));  // R9

  AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(layer_in) |-> !$isunknown(layer_out));  // R11

endmodule

bind gate_layer gate_layer_chk #(
  .IN_W  (IN_W),
  .N_NEU (N_NEU),
  .IDX_W (IDX_W),
  .NID_W (NID_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_neuron (cfg_neuron),
  .cfg_src_a  (cfg_src_a),
  .cfg_src_b  (cfg_src_b),
  .cfg_code   (cfg_code),
  .layer_in   (layer_in),
  .layer_out  (layer_out)
);

// File: tb/sim_gate_layer.sv
`timescale 1ns/1ps
module sim_gate_layer;

  localparam int IN_W  = 16;
  localparam int N_NEU = 8;
  localparam int IDX_W = $clog2(IN_W) + 1;
  localparam int NID_W = $clog2(N_NEU) + 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [NID_W-1:0] cfg_neuron = '0;
  logic [IDX_W-1:0] cfg_src_a = '0;
  logic [IDX_W-1:0] cfg_src_b = '0;
  logic [3:0]       cfg_code = '0;
  logic [IN_W-1:0]  layer_in = '0;
  logic [N_NEU-1:0] layer_out;

  always #2 clk = ~clk;

  gate_layer #(.IN_W(IN_W), .N_NEU(N_NEU)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_neuron(cfg_neuron),
    .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .cfg_code(cfg_code),
    .layer_in(layer_in), .layer_out(layer_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_code [N_NEU];
  int m_a    [N_NEU];
  int m_b    [N_NEU];

  logic [N_NEU-1:0] exp_q [$];
  string            tag_q [$];

  function automatic logic ref_gate(int c, logic a, logic b);
    case (c)
      0: return 1'b0;
      1: return a & b;
      2: return a & ~b;
      3: return a;
      4: return ~a & b;
      5: return b;
      6: return a ^ b;
      7: return a | b;
      8: return ~(a | b);
      9: return ~(a ^ b);
      10: return ~b;
      11: return ~b | a;
      12: return ~a;
      13: return ~a | b;
      14: return ~(a & b);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [N_NEU-1:0] ref_layer(logic [IN_W-1:0] v);
    logic [N_NEU-1:0] r;
    for (int n = 0; n < N_NEU; n++) begin
      logic a, b;
      a = (m_a[n] < IN_W) ? v[m_a[n]] : 1'b0;
      b = (m_b[n] < IN_W) ? v[m_b[n]] : 1'b0;
      r[n] = ref_gate(m_code[n], a, b);
    end
    return r;
  endfunction

  function automatic void model_reset();
    for (int n = 0; n < N_NEU; n++) begin
      m_code[n] = 3; m_a[n] = 0; m_b[n] = 0;
    end
  endfunction

  function automatic void model_write(int n, int a, int b, int c);
    if (n < N_NEU) begin
      m_code[n] = c; m_a[n] = a; m_b[n] = b;
    end
  endfunction

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1 rst = 1'b0;
    model_reset();
  endtask

  task automatic probe(logic [IN_W-1:0] v, string tag);
    @(posedge clk); #1;
    layer_in = v;
    exp_q.push_back(ref_layer(v));
    tag_q.push_back(tag);
  endtask

  task automatic do_write(int n, int a, int b, int c);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_neuron = NID_W'(n);
    cfg_src_a = IDX_W'(a); cfg_src_b = IDX_W'(b); cfg_code = 4'(c);
    @(posedge clk); #1 cfg_we = 1'b0;
    model_write(n, a, b, c);
  endtask

  // Write presented together with an input; the old setting is expected.
  task automatic write_and_probe(int n, int a, int b, int c, logic [IN_W-1:0] v, string tag);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_neuron = NID_W'(n);
    cfg_src_a = IDX_W'(a); cfg_src_b = IDX_W'(b); cfg_code = 4'(c);
    layer_in = v;
    exp_q.push_back(ref_layer(v));
    tag_q.push_back(tag);
    @(posedge clk); #1 cfg_we = 1'b0;
    model_write(n, a, b, c);
  endtask

  // Scoreboard monitor: pops one expectation per cycle at the falling edge.
  always @(negedge clk) begin
    if (exp_q.size() != 0 && !done) begin
      logic [N_NEU-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ($isunknown(layer_out)) begin
        errors++;
        $display("FAIL R11 (%s): layer_out=%b expected=no X/Z", t, layer_out);
      end
      checks++;
      if (layer_out !== e) begin
        errors++;
        $display("FAIL %s: layer_out=%h expected=%h", t, layer_out, e);
      end
    end
  end

  logic [IN_W-1:0] pats [6] = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'hA5C3, 16'h3C5A};

  initial begin
    model_reset();
    do_reset();

    // R1: reset state copies input bit 0 to every neuron
    probe(16'h0001, "R1");
    probe(16'hFFFE, "R1");
    probe(16'h8001, "R1 R10");
    probe(16'h8000, "R1 R10");

    // R3 R4: codes 0..7, a from bit i, b from bit i+8
    for (int i = 0; i < N_NEU; i++) do_write(i, i, i + 8, i);
    foreach (pats[p]) probe(pats[p], "R3 R4");

    // R5 R6: codes 8..15
    for (int i = 0; i < N_NEU; i++) do_write(i, i, i + 8, i + 8);
    foreach (pats[p]) probe(pats[p], "R5 R6");

    // R2: old setting during the write cycle, new one after the edge
    write_and_probe(0, 0, 8, 15, 16'h00FF, "R2");
    probe(16'h00FF, "R2");
    write_and_probe(7, 3, 4, 6, 16'h0008, "R2");
    probe(16'h0008, "R2");

    // R7: operand index at and beyond the input width reads 0
    do_write(1, 20, 9, 3);
    do_write(2, 2, 31, 5);
    do_write(3, 16, 3, 3);
    probe(16'hFFFF, "R7");
    do_write(4, 4, 16, 7);
    probe(16'h0000, "R7");
    probe(16'hFFFF, "R7");

    // R8: neuron numbers past N_NEU change nothing
    write_and_probe(9, 0, 0, 0, 16'hFFFF, "R8");
    probe(16'hFFFF, "R8");
    do_write(15, 5, 5, 15);
    probe(16'h0000, "R8");
    probe(16'h5A5A, "R8");

    // R9: fields move while the strobe stays low
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_neuron = '0; cfg_src_a = 5'd9; cfg_src_b = 5'd1; cfg_code = 4'd0;
    @(posedge clk); #1 cfg_neuron = 4'd5; cfg_code = 4'd15;
    probe(16'hFFFF, "R9");
    probe(16'h0000, "R9");

    // R1 again after a mid-run reset
    do_reset();
    probe(16'h0001, "R1");
    probe(16'h1234, "R1");

    wait (exp_q.size() == 0);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (R1..all): actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule